// File: doc/BRIEF.md
# Banked Level-Interrupt Controller

This block gathers 72 level-sensitive interrupt lines and drives one interrupt request to a processor. The lines come in three groups: two peripheral banks of 32 lines each and one local bank of 8 lines. Each bank has its own enable mask. Software changes a mask through a pair of write-only-in-effect ports. One port turns enables on and the other turns them off. Both ports read back the current mask.

For each peripheral bank, a pending view shows the live input level ANDed with that bank's enable mask. Nothing is latched: a pending bit drops as soon as its line drops or its enable is removed. A 21-bit summary word lets a handler decide quickly where to look. It carries:
- the enabled local lines;
- a "look further" flag for each peripheral bank;
- shortcut copies of eleven chosen peripheral lines.

The request output is the OR of the summary word, delayed by one register stage.

Top module: `banked_irq_ctrl`

## Requirements
- R1: A write to the set port of a bank (word address 0x4 for peripheral bank 1, 0x5 for peripheral bank 2, 0x6 for local) turns on every enable whose data bit is 1 and leaves the others unchanged. A read of that address returns the bank's enable mask, zero-extended.
- R2: A write to the clear port of a bank (0x8, 0x9, 0xA, same bank order) turns off every enable whose data bit is 1 and leaves the others unchanged. A read of that address returns the bank's enable mask.
- R3: Reading 0x1 or 0x2 returns the live source levels of peripheral bank 1 or 2, ANDed with that bank's enable mask, with no latching.
- R4: Summary word (address 0x0) bits 7..0 are the local source levels ANDed with the local enables.
- R5: Summary bit 8 (bank 1) and bit 9 (bank 2) are 1 exactly when that bank has an enabled, active line that is not one of its shortcut lines.
- R6: Summary bits 14..10 copy the enabled state of bank-1 lines 7, 9, 10, 18, 19, in that order from bit 10. Bits 20..15 copy bank-2 lines 21, 22, 23, 24, 25, 30, in that order from bit 15.
- R7: Summary bits 31..21 read 0. The summary word is 0 exactly when no enabled line in any bank is active.
- R8: The request output goes high in the cycle after the summary word becomes nonzero, and goes low in the cycle after it becomes zero.
- R9: Under synchronous active-high reset, all enables clear and the request output is low.
- R10: Writes to 0x0, 0x1, 0x2 and to unmapped addresses change no enable. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_bank1_i | input | 32 | Peripheral bank 1 levels |
| src_bank2_i | input | 32 | Peripheral bank 2 levels |
| src_local_i | input | 8 | Local bank levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write mask |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two things can happen in the same clock edge: an enable write (set or clear) and a change in source level. The bench provokes this in two ways. In directed steps, a clear write lands on the very cycle a line rises, and a set write lands on the cycle a line falls. In a long random phase, every cycle carries new levels, and one cycle in three also carries a write. A behavioural model recomputes the expected read data and the one-cycle-late request at every clock. Each comparison is judged against the requirement of the address being read, so a wrong order between masking and the enable update shows up both in the pending view and in the request timing.

// File: rtl/ic_pkg.sv
package ic_pkg;

    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 4;
    parameter int BANK_W  = 32;
    parameter int LOCAL_W = 8;
    parameter int SC1_N   = 5;
    parameter int SC2_N   = 6;
    parameter int NBANK   = 3;
    parameter int IDX_W   = $clog2(BANK_W);

    localparam int SET_BASE = 4;
    localparam int CLR_BASE = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_SUMMARY = 4'h0,
        RA_PEND1   = 4'h1,
        RA_PEND2   = 4'h2,
        RA_SET1    = 4'h4,
        RA_SET2    = 4'h5,
        RA_SETL    = 4'h6,
        RA_CLR1    = 4'h8,
        RA_CLR2    = 4'h9,
        RA_CLRL    = 4'hA
    } reg_addr_e;

    typedef enum int {
        BK_P1  = 0,
        BK_P2  = 1,
        BK_LOC = 2
    } bank_e;

    typedef struct packed {
        logic [SC2_N-1:0]   sc2;
        logic [SC1_N-1:0]   sc1;
        logic               more2;
        logic               more1;
        logic [LOCAL_W-1:0] loc;
    } summary_t;

    localparam int SUM_W = $bits(summary_t);

    function automatic logic [DATA_W-1:0] zext_sum(input summary_t s);
        logic [DATA_W-1:0] r;
        r = '0;
        r[SUM_W-1:0] = s;
        return r;
    endfunction

endpackage

// File: rtl/ic_enable_bank.sv
module ic_enable_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] en_o
);

    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (set_we) begin
            en_q <= en_q | wmask;
        end else if (clr_we) begin
            en_q <= en_q & ~wmask;
        end
    end

    assign en_o = en_q;

    // R1: written ones become enabled, others untouched
    p_set_on_r1: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_o & $past(wmask)) == $past(wmask)));
    p_set_keep_r1: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_o & $past(en_o)) == $past(en_o)));
    // R2: written ones become disabled, others untouched
    p_clr_off_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((en_o & $past(wmask)) == '0));
    p_clr_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((en_o | $past(wmask)) == ($past(en_o) | $past(wmask))));
    // R10: no strobe, no change
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(en_o));
    // R9: reset empties the mask
    p_reset_empty_r9: assert property (@(posedge clk)
        rst |=> (en_o == '0));

endmodule

// File: rtl/ic_summary.sv
module ic_summary
    import ic_pkg::*;
#(
    parameter logic [SC1_N*IDX_W-1:0] SC1_IDX = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7},
    parameter logic [SC2_N*IDX_W-1:0] SC2_IDX = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BANK_W-1:0]  pend1_i,
    input  logic [BANK_W-1:0]  pend2_i,
    input  logic [LOCAL_W-1:0] pend_loc_i,
    output summary_t           sum_o
);

    logic [BANK_W-1:0] mirror1, mirror2;
    logic [SC1_N-1:0]  sc1_bits;
    logic [SC2_N-1:0]  sc2_bits;

    always_comb begin
        mirror1 = '0;
        for (int i = 0; i < SC1_N; i++) begin
            mirror1[SC1_IDX[i*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    always_comb begin
        mirror2 = '0;
        for (int i = 0; i < SC2_N; i++) begin
            mirror2[SC2_IDX[i*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    for (genvar g = 0; g < SC1_N; g++) begin : g_sc1
        assign sc1_bits[g] = pend1_i[SC1_IDX[g*IDX_W +: IDX_W]];
    end

    for (genvar g = 0; g < SC2_N; g++) begin : g_sc2
        assign sc2_bits[g] = pend2_i[SC2_IDX[g*IDX_W +: IDX_W]];
    end

    always_comb begin
        sum_o.loc   = pend_loc_i;
        sum_o.more1 = |(pend1_i & ~mirror1);
        sum_o.more2 = |(pend2_i & ~mirror2);
        sum_o.sc1   = sc1_bits;
        sum_o.sc2   = sc2_bits;
    end

    // R5: a bank flag never rises without some pending line in that bank
    p_more1_src_r5: assert property (@(posedge clk) disable iff (rst)
        sum_o.more1 |-> (pend1_i != '0));
    p_more2_src_r5: assert property (@(posedge clk) disable iff (rst)
        sum_o.more2 |-> (pend2_i != '0));
    // R7: an empty summary means nothing enabled is active anywhere
    p_zero_all_r7: assert property (@(posedge clk) disable iff (rst)
        (sum_o == '0) |-> (pend1_i == '0 && pend2_i == '0 && pend_loc_i == '0));
    // R6: a single pending bank-1 line gives at most one bank-1 indication
    p_one_view_r6: assert property (@(posedge clk) disable iff (rst)
        ($countones(pend1_i) == 1) |-> $onehot({sum_o.more1, sum_o.sc1}));

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import ic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [BANK_W-1:0]  src_bank1_i,
    input  logic [BANK_W-1:0]  src_bank2_i,
    input  logic [LOCAL_W-1:0] src_local_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    logic [NBANK-1:0]   set_we, clr_we;
    logic [BANK_W-1:0]  en_per [2];
    logic [LOCAL_W-1:0] en_loc;
    logic [BANK_W-1:0]  pend1, pend2;
    logic [LOCAL_W-1:0] pend_loc;
    summary_t           sum;
    logic               irq_q;

    // address decode: set and clear ports sit at base plus bank index
    always_comb begin
        set_we = '0;
        clr_we = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (reg_wr_i && (int'(reg_addr_i) == SET_BASE + b)) set_we[b] = 1'b1;
            if (reg_wr_i && (int'(reg_addr_i) == CLR_BASE + b)) clr_we[b] = 1'b1;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_per
        ic_enable_bank #(.W(BANK_W)) i_en (
            .clk    (clk),
            .rst    (rst),
            .set_we (set_we[b]),
            .clr_we (clr_we[b]),
            .wmask  (reg_wdata_i[BANK_W-1:0]),
            .en_o   (en_per[b])
        );
    end

    ic_enable_bank #(.W(LOCAL_W)) i_en_loc (
        .clk    (clk),
        .rst    (rst),
        .set_we (set_we[BK_LOC]),
        .clr_we (clr_we[BK_LOC]),
        .wmask  (reg_wdata_i[LOCAL_W-1:0]),
        .en_o   (en_loc)
    );

    assign pend1    = src_bank1_i & en_per[BK_P1];
    assign pend2    = src_bank2_i & en_per[BK_P2];
    assign pend_loc = src_local_i & en_loc;

    ic_summary i_sum (
        .clk        (clk),
        .rst        (rst),
        .pend1_i    (pend1),
        .pend2_i    (pend2),
        .pend_loc_i (pend_loc),
        .sum_o      (sum)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_e'(reg_addr_i))
            RA_SUMMARY:         reg_rdata_o = zext_sum(sum);
            RA_PEND1:           reg_rdata_o[BANK_W-1:0] = pend1;
            RA_PEND2:           reg_rdata_o[BANK_W-1:0] = pend2;
            RA_SET1, RA_CLR1:   reg_rdata_o[BANK_W-1:0] = en_per[BK_P1];
            RA_SET2, RA_CLR2:   reg_rdata_o[BANK_W-1:0] = en_per[BK_P2];
            RA_SETL, RA_CLRL:   reg_rdata_o[LOCAL_W-1:0] = en_loc;
            default:            reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (sum != '0);
    end

    assign irq_o = irq_q;

    // R8: request trails the summary by one register
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (sum != '0) |=> irq_o);
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (sum == '0) |=> !irq_o);
    // R3: pending view never shows a disabled line
    p_pend_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == RA_PEND1) |-> ((reg_rdata_o & ~en_per[BK_P1]) == '0));
    // R10: a write to a read-only word leaves every mask alone
    p_ro_write_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i <= RA_PEND2) |=>
            ($stable(en_per[BK_P1]) && $stable(en_per[BK_P2]) && $stable(en_loc)));
    // R9: request is low after a reset cycle
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> !irq_o);

endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src1 = '0, src2 = '0;
    logic [7:0]  srcl = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    localparam int SC1 [5] = '{7, 9, 10, 18, 19};
    localparam int SC2 [6] = '{21, 22, 23, 24, 25, 30};

    always #2 clk = ~clk;

    banked_irq_ctrl i_banked_irq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .src_bank1_i (src1),
        .src_bank2_i (src2),
        .src_local_i (srcl),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // behavioural reference state
    logic [31:0] m_en1 = '0, m_en2 = '0;
    logic [7:0]  m_enl = '0;
    logic        m_irq = 1'b0;

    function automatic logic [31:0] m_summary();
        logic [31:0] s  = '0;
        logic [31:0] p1 = src1 & m_en1;
        logic [31:0] p2 = src2 & m_en2;
        s[7:0] = srcl & m_enl;
        for (int k = 0; k < 5; k++) begin
            s[10+k] = p1[SC1[k]];
            p1[SC1[k]] = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            s[15+k] = p2[SC2[k]];
            p2[SC2[k]] = 1'b0;
        end
        s[8] = (p1 != 0);
        s[9] = (p2 != 0);
        return s;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return m_summary();
            4'h1: return src1 & m_en1;
            4'h2: return src2 & m_en2;
            4'h4, 4'h8: return m_en1;
            4'h5, 4'h9: return m_en2;
            4'h6, 4'hA: return {24'h0, m_enl};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'h0: return "R4 R5 R6 R7 summary";
            4'h1, 4'h2: return "R3 pending";
            4'h4, 4'h5, 4'h6: return "R1 set";
            4'h8, 4'h9, 4'hA: return "R2 clear";
            default: return "R10 unmapped";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en1 <= '0; m_en2 <= '0; m_enl <= '0; m_irq <= 1'b0;
        end else begin
            m_irq <= (m_summary() != 0);
            if (wr) begin
                case (addr)
                    4'h4: m_en1 <= m_en1 | wdata;
                    4'h5: m_en2 <= m_en2 | wdata;
                    4'h6: m_enl <= m_enl | wdata[7:0];
                    4'h8: m_en1 <= m_en1 & ~wdata;
                    4'h9: m_en2 <= m_en2 & ~wdata;
                    4'hA: m_enl <= m_enl & ~wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // compare every cycle, just after the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        n_chk++;
        if (rdata !== m_read(addr)) begin
            n_err++;
            $display("FAIL %s addr %0h actual %h expected %h",
                     rst ? "R9 reset" : req_of(addr), addr, rdata, m_read(addr));
        end
        n_chk++;
        if (irq !== m_irq) begin
            n_err++;
            $display("FAIL %s irq actual %b expected %b",
                     rst ? "R9 reset" : "R8 request", irq, m_irq);
        end
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog actual %0d expected below 20000", cyc);
            report();
        end
    end

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = w; addr = a; wdata = d;
    endtask

    initial begin
        src1 = '1; src2 = '1; srcl = '1;   // R9: everything active yet masked off
        repeat (3) step(1'b0, 4'h0, '0);
        @(negedge clk); rst = 1'b0;
        step(1'b0, 4'h0, '0);
        // R1: set bits, zero bits keep state
        src1 = '0; src2 = '0; srcl = '0;
        step(1'b1, 4'h4, 32'h0000_0681);
        step(1'b0, 4'h4, '0);
        step(1'b1, 4'h4, 32'h0);
        step(1'b0, 4'h8, '0);
        // R6 / R5: only a shortcut line pending in bank 1
        src1 = 32'h0000_0080;
        step(1'b0, 4'h0, '0);
        step(1'b0, 4'h1, '0);
        // R5: a non-shortcut line sets the bank flag
        src1 = 32'h0000_0081;
        step(1'b0, 4'h0, '0);
        // R4: local bank
        step(1'b1, 4'h6, 32'h0000_00A5);
        srcl = 8'hFF;
        step(1'b0, 4'h0, '0);
        // R2: clear a subset, clear with zero
        step(1'b1, 4'hA, 32'h0000_0005);
        step(1'b1, 4'hA, 32'h0);
        step(1'b0, 4'h6, '0);
        // R6 bank 2 shortcut and R5 bank 2 flag
        step(1'b1, 4'h5, 32'h4020_0001);
        src2 = 32'h4000_0000;
        step(1'b0, 4'h0, '0);
        src2 = 32'h4000_0001;
        step(1'b0, 4'h2, '0);
        // R10: writes to read-only and unmapped words
        step(1'b1, 4'h0, 32'hFFFF_FFFF);
        step(1'b1, 4'h1, 32'hFFFF_FFFF);
        step(1'b1, 4'h3, 32'hFFFF_FFFF);
        step(1'b1, 4'hF, 32'hFFFF_FFFF);
        step(1'b0, 4'h4, '0);
        step(1'b0, 4'h5, '0);
        step(1'b0, 4'h7, '0);
        // concurrent: clear lands as a line rises, set lands as a line falls
        src1 = 32'h0000_0103;
        step(1'b1, 4'h8, 32'h0000_0001);
        src1 = 32'h0000_0000;
        step(1'b1, 4'h4, 32'h0000_0100);
        step(1'b0, 4'h0, '0);
        // R7: everything off, summary zero, request drops (R8)
        step(1'b1, 4'h8, '1);
        step(1'b1, 4'h9, '1);
        step(1'b1, 4'hA, '1);
        step(1'b0, 4'h0, '0);
        step(1'b0, 4'h0, '0);
        // random mixed traffic
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            src1 = $urandom & $urandom;
            src2 = $urandom & $urandom;
            srcl = 8'($urandom);
            wr    = ($urandom % 3) == 0;
            addr  = 4'($urandom);
            wdata = $urandom & $urandom;
        end
        step(1'b0, 4'h0, '0);
        step(1'b0, 4'h0, '0);
        report();
    end

endmodule